// File: doc/BRIEF.md
# Banked Binary Point Register Unit

This block keeps two 3-bit binary point settings, one for group-0 interrupts and one for group-1 interrupts. Each setting marks where an 8-bit interrupt priority divides into an upper group-priority part and a lower subpriority part. Only the group-priority part takes part in preemption decisions. For each group the block drives the current binary point and an 8-bit mask that keeps the group-priority bits and clears the subpriority bits. A priority arbiter can AND a priority with the mask before it compares preemption levels.

Software reaches both settings through a simple 32-bit register port. A select line picks the group-0 or the group-1 register, and a qualifier marks each access as secure or non-secure. Only bits [2:0] of each register hold state. A write below a field's minimum stores the minimum, and the group-1 minimum is always one above the group-0 minimum. A common-mode input ties group 1 to group 0. While it is set, the group-1 view is derived from the group-0 field. Non-secure group-1 writes are dropped, and secure group-1 accesses are redirected to the group-0 field.

Reads return data in the same cycle as the read strobe. Writes take effect on the next rising clock edge.

Top module: `bpr_unit`

## Requirements
- R1: After reset the group-0 field holds MIN_BP0 and the group-1 field holds MIN_BP0+1. With the default MIN_BP0 = 0, bp0_out is 0, bp1_out is 1 and both masks are 8'hFE.
- R2: A write with sel_grp1 = 0 stores wdata[2:0] in the group-0 field on the next rising edge. A value below MIN_BP0 is stored as MIN_BP0. A read with sel_grp1 = 0 returns the group-0 field in rdata[2:0].
- R3: While common_mode = 0, a write with sel_grp1 = 1 stores wdata[2:0] in the group-1 field, and a value below MIN_BP0+1 is stored as MIN_BP0+1. A read with sel_grp1 = 1 returns that field.
- R4: rdata[31:3] always reads as zero, and wdata[31:3] has no effect on any stored field.
- R5: While common_mode = 1, a non-secure read (secure = 0, sel_grp1 = 1) returns the group-0 field plus one, held at 7 when the group-0 field is 7.
- R6: While common_mode = 1, a non-secure write with sel_grp1 = 1 changes neither field.
- R7: While common_mode = 1, a secure read with sel_grp1 = 1 returns the group-0 field unchanged. A secure write with sel_grp1 = 1 stores into the group-0 field, using the group-0 minimum, and leaves the stored group-1 field unchanged.
- R8: mask0 is 8'hFF shifted left by bp0_out+1, so it is 0 when bp0_out is 7. mask1 is 8'hFF shifted left by bp1_out.
- R9: bp1_out shows the stored group-1 field while common_mode = 0. While common_mode = 1 it shows the group-0 field plus one, held at 7.
- R10: rdata is all zeros whenever rd_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; loads both fields with their minimums |
| common_mode | input | 1 | 1 derives the group-1 view from the group-0 field |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| sel_grp1 | input | 1 | Register select: 0 = group-0 register, 1 = group-1 register |
| secure | input | 1 | Access qualifier: 1 = secure, 0 = non-secure |
| wdata | input | DATA_W | Write data; only bits [2:0] are used |
| rdata | output | DATA_W | Read data, valid in the same cycle as rd_en |
| bp0_out | output | 3 | Group-0 binary point |
| bp1_out | output | 3 | Effective group-1 binary point |
| mask0 | output | 8 | Group-priority mask for group 0 |
| mask1 | output | 8 | Group-priority mask for group 1 |

## Verification
The bench sweeps the group-0 field through 0, 3, 6 and 7 under common mode. A design that let the plus-one read wrap would return 0 at the top value instead of 7, and the mask at that point must be all zeros. The bench writes values below the minimum to both fields, on a second instance whose group-0 minimum is raised. This exposes a design that stores the raw value, or that clamps the group-1 field against the group-0 minimum. Under common mode, the bench checks that non-secure group-1 writes do not reach the stored group-1 field and that secure ones land in group 0. It does this by clearing common mode afterwards and reading the stored value back. The bench also writes data with non-zero upper bits, which exposes a design that leaks those bits into the read path.

// File: rtl/bpr_pkg.sv
package bpr_pkg;

  localparam int BP_W   = 3;
  localparam int PRIO_W = 8;

  typedef logic [BP_W-1:0]   bp_t;
  typedef logic [PRIO_W-1:0] prio_mask_t;

  // Source feeding the read data path
  typedef enum logic [1:0] {
    RD_NONE    = 2'd0,
    RD_BP0     = 2'd1,
    RD_BP1     = 2'd2,
    RD_BP0_INC = 2'd3
  } rd_src_e;

  typedef struct packed {
    logic    wr_g0;
    logic    wr_g1;
    rd_src_e rd_src;
  } route_t;

  // Raise a requested value to the field floor
  function automatic bp_t bp_clamp(input bp_t val, input bp_t floor_v);
    return (val < floor_v) ? floor_v : val;
  endfunction

  // Add one, holding at the all-ones value
  function automatic bp_t bp_sat_inc(input bp_t val);
    return (val == {BP_W{1'b1}}) ? val : bp_t'(val + 1'b1);
  endfunction

  // Keep priority bits at and above position bp+offset
  function automatic prio_mask_t grp_mask(input bp_t bp, input int offset);
    int sh;
    sh = int'(bp) + offset;
    if (sh >= PRIO_W) return '0;
    return prio_mask_t'({PRIO_W{1'b1}} << sh);
  endfunction

endpackage

// File: rtl/bpr_route.sv
module bpr_route
  import bpr_pkg::*;
(
  input  logic   wr_en,
  input  logic   rd_en,
  input  logic   sel_grp1,
  input  logic   secure,
  input  logic   common_mode,
  output route_t route
);

  always_comb begin
    route.wr_g0  = 1'b0;
    route.wr_g1  = 1'b0;
    route.rd_src = RD_NONE;
    if (!sel_grp1) begin
      route.wr_g0 = wr_en;
      if (rd_en) route.rd_src = RD_BP0;
    end else if (!common_mode) begin
      route.wr_g1 = wr_en;
      if (rd_en) route.rd_src = RD_BP1;
    end else if (secure) begin
      // common mode, secure: redirected to group 0
      route.wr_g0 = wr_en;
      if (rd_en) route.rd_src = RD_BP0;
    end else begin
      // common mode, non-secure: write dropped, read derived
      if (rd_en) route.rd_src = RD_BP0_INC;
    end
  end

endmodule

// File: rtl/bpr_field.sv
module bpr_field
  import bpr_pkg::*;
#(
  parameter int MIN_VAL = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  bp_t  wr_val,
  output bp_t  value
);

  localparam bp_t FLOOR = bp_t'(MIN_VAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     value <= FLOOR;
    else if (wr_en) value <= bp_clamp(wr_val, FLOOR);
  end

endmodule

// File: rtl/bpr_mask_gen.sv
module bpr_mask_gen
  import bpr_pkg::*;
#(
  parameter int OFFSET = 0
) (
  input  bp_t        bp,
  output prio_mask_t mask
);

  assign mask = grp_mask(bp, OFFSET);

endmodule

// File: rtl/bpr_unit.sv
module bpr_unit
  import bpr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int MIN_BP0 = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              common_mode,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              sel_grp1,
  input  logic              secure,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [BP_W-1:0]   bp0_out,
  output logic [BP_W-1:0]   bp1_out,
  output logic [PRIO_W-1:0] mask0,
  output logic [PRIO_W-1:0] mask1
);

  localparam int MIN_BP1 = MIN_BP0 + 1;

  route_t route;
  bp_t    wr_val;
  bp_t    bp0_q;
  bp_t    bp1_q;
  bp_t    bp0_inc;
  bp_t    bp1_eff;
  bp_t    rd_val;
  logic   unused_wdata_hi;

  assign wr_val          = wdata[BP_W-1:0];
  assign unused_wdata_hi = ^wdata[DATA_W-1:BP_W];

  bpr_route u_route (
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .sel_grp1    (sel_grp1),
    .secure      (secure),
    .common_mode (common_mode),
    .route       (route)
  );

  bpr_field #(.MIN_VAL(MIN_BP0)) u_field0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (route.wr_g0),
    .wr_val (wr_val),
    .value  (bp0_q)
  );

  bpr_field #(.MIN_VAL(MIN_BP1)) u_field1 (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (route.wr_g1),
    .wr_val (wr_val),
    .value  (bp1_q)
  );

  assign bp0_inc = bp_sat_inc(bp0_q);
  assign bp1_eff = common_mode ? bp0_inc : bp1_q;

  always_comb begin
    unique case (route.rd_src)
      RD_BP0:     rd_val = bp0_q;
      RD_BP1:     rd_val = bp1_q;
      RD_BP0_INC: rd_val = bp0_inc;
      default:    rd_val = '0;
    endcase
  end

  assign rdata   = {{(DATA_W-BP_W){1'b0}}, rd_val};
  assign bp0_out = bp0_q;
  assign bp1_out = bp1_eff;

  // Group 0 keeps one fewer bit than its binary point; group 1 keeps bp itself
  for (genvar g = 0; g < 2; g++) begin : g_mask
    bp_t        src;
    prio_mask_t m;
    assign src = (g == 0) ? bp0_q : bp1_eff;
    bpr_mask_gen #(.OFFSET(g == 0 ? 1 : 0)) u_mask (
      .bp   (src),
      .mask (m)
    );
  end

  assign mask0 = g_mask[0].m;
  assign mask1 = g_mask[1].m;

endmodule

// File: rtl/bpr_unit_chk.sv
module bpr_unit_chk
  import bpr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int MIN_BP0 = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              common_mode,
  input logic              wr_en,
  input logic              rd_en,
  input logic              sel_grp1,
  input logic              secure,
  input logic [DATA_W-1:0] rdata,
  input logic [BP_W-1:0]   bp0_out,
  input logic [BP_W-1:0]   bp1_out,
  input logic [PRIO_W-1:0] mask0,
  input logic [PRIO_W-1:0] mask1,
  input logic [BP_W-1:0]   bp1_q
);

  AST_BP0_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bp0_out) >= MIN_BP0); // R2

  AST_BP1_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bp1_q) >= MIN_BP0 + 1); // R3

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:BP_W] == '0); // R4

  AST_NS_INC_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_grp1 && common_mode && !secure) |->
      (int'(rdata[BP_W-1:0]) == ((bp0_out == 3'd7) ? 7 : int'(bp0_out) + 1))); // R5

  AST_NS_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_grp1 && common_mode && !secure) |=>
      ($stable(bp0_out) && $stable(bp1_q))); // R6

  AST_SEC_KEEPS_G1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_grp1 && common_mode && secure) |=> $stable(bp1_q)); // R7

  AST_SEC_READ_G0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_grp1 && common_mode && secure) |->
      (rdata[BP_W-1:0] == bp0_out)); // R7

  AST_MASK0_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mask0) == 7 - int'(bp0_out)); // R8

  AST_MASK1_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mask1) == 8 - int'(bp1_out)); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0)); // R10

endmodule

bind bpr_unit bpr_unit_chk #(.DATA_W(DATA_W), .MIN_BP0(MIN_BP0)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .common_mode (common_mode),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .sel_grp1    (sel_grp1),
  .secure      (secure),
  .rdata       (rdata),
  .bp0_out     (bp0_out),
  .bp1_out     (bp1_out),
  .mask0       (mask0),
  .mask1       (mask1),
  .bp1_q       (bp1_q)
);

// File: tb/tb_bpr_unit.sv
`timescale 1ns/1ps
module tb_bpr_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        common_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic        sel_grp1 = 1'b0;
  logic        secure = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, c_rdata;
  logic [2:0]  bp0_out, bp1_out, c_bp0, c_bp1;
  logic [7:0]  mask0, mask1, c_mask0, c_mask1;

  int checks = 0;
  int errors = 0;

  // bench-side view of the stored fields (dut: floor 0/1, dut_c: floor 2/3)
  int m0 = 0, m1 = 1, c0 = 2, c1 = 3;

  always #4 clk = ~clk; // 125 MHz

  bpr_unit dut (
    .clk(clk), .rst_n(rst_n), .common_mode(common_mode), .wr_en(wr_en),
    .rd_en(rd_en), .sel_grp1(sel_grp1), .secure(secure), .wdata(wdata),
    .rdata(rdata), .bp0_out(bp0_out), .bp1_out(bp1_out),
    .mask0(mask0), .mask1(mask1)
  );

  bpr_unit #(.MIN_BP0(2)) dut_c (
    .clk(clk), .rst_n(rst_n), .common_mode(common_mode), .wr_en(wr_en),
    .rd_en(rd_en), .sel_grp1(sel_grp1), .secure(secure), .wdata(wdata),
    .rdata(c_rdata), .bp0_out(c_bp0), .bp1_out(c_bp1),
    .mask0(c_mask0), .mask1(c_mask1)
  );

  function automatic int floor_to(int v, int f);
    return (v < f) ? f : v;
  endfunction

  function automatic int plus_one_sat(int v);
    return (v >= 7) ? 7 : v + 1;
  endfunction

  function automatic logic [7:0] exp_mask(int keep_from);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = (i >= keep_from);
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic sel, input logic sec, input logic [31:0] d);
    int v;
    @(negedge clk);
    wr_en = 1'b1; sel_grp1 = sel; secure = sec; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    v = int'(d[2:0]);
    if (!sel) begin
      m0 = floor_to(v, 0); c0 = floor_to(v, 2);
    end else if (!common_mode) begin
      m1 = floor_to(v, 1); c1 = floor_to(v, 3);
    end else if (sec) begin
      m0 = floor_to(v, 0); c0 = floor_to(v, 2);
    end
  endtask

  task automatic do_read(input logic sel, input logic sec,
                         output logic [31:0] r, output logic [31:0] rc);
    @(negedge clk);
    rd_en = 1'b1; sel_grp1 = sel; secure = sec;
    #1;
    r = rdata; rc = c_rdata;
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 bp0 reset", 32'(bp0_out), 32'd0);
    check("R1 bp1 reset", 32'(bp1_out), 32'd1);
    check("R1 mask0 reset", 32'(mask0), 32'hFE);
    check("R1 mask1 reset", 32'(mask1), 32'hFE);
    check("R1 raised-floor bp0 reset", 32'(c_bp0), 32'd2);
    check("R1 raised-floor bp1 reset", 32'(c_bp1), 32'd3);
  endtask

  task automatic t_grp0_rw();
    logic [31:0] r, rc;
    do_write(1'b0, 1'b0, 32'hABCD_EF05);
    check("R2 bp0 after write", 32'(bp0_out), 32'd5);
    do_read(1'b0, 1'b0, r, rc);
    check("R2 group-0 read", r, 32'd5);
    check("R4 upper bits zero, high wdata ignored", r, 32'h0000_0005);
  endtask

  task automatic t_grp1_floor();
    logic [31:0] r, rc;
    do_write(1'b1, 1'b0, 32'hFFFF_FFF8);
    do_read(1'b1, 1'b0, r, rc);
    check("R3 group-1 write of 0 floored", r, 32'd1);
    check("R3 raised floor group-1", rc, 32'd3);
    do_write(1'b1, 1'b1, 32'd6);
    do_read(1'b1, 1'b0, r, rc);
    check("R3 group-1 write 6", r, 32'd6);
    check("R9 bp1_out shows stored field", 32'(bp1_out), 32'd6);
    do_write(1'b1, 1'b0, 32'd2);
    do_read(1'b1, 1'b0, r, rc);
    check("R3 raised floor keeps 3", rc, 32'(c1));
    do_write(1'b0, 1'b0, 32'd1);
    do_read(1'b0, 1'b0, r, rc);
    check("R2 group-0 floor on raised instance", rc, 32'd2);
    check("R2 group-0 value 1 stored at default floor", r, 32'd1);
    do_write(1'b1, 1'b0, 32'd6);
  endtask

  task automatic t_idle();
    @(negedge clk);
    rd_en = 1'b0; sel_grp1 = 1'b1;
    #1;
    check("R10 idle rdata", rdata, 32'd0);
  endtask

  task automatic t_common_ns_read();
    logic [31:0] r, rc;
    int vals[4] = '{0, 3, 6, 7};
    common_mode = 1'b1;
    foreach (vals[i]) begin
      do_write(1'b0, 1'b0, 32'(vals[i]));
      do_read(1'b1, 1'b0, r, rc);
      check("R5 non-secure derived read", r, 32'(plus_one_sat(vals[i])));
      check("R9 bp1_out derived", 32'(bp1_out), 32'(plus_one_sat(vals[i])));
      check("R8 mask1 under common mode", 32'(mask1), 32'(exp_mask(plus_one_sat(vals[i]))));
      check("R8 mask0", 32'(mask0), 32'(exp_mask(vals[i] + 1)));
    end
  endtask

  task automatic t_common_ns_write();
    logic [31:0] r, rc;
    common_mode = 1'b1;
    do_write(1'b0, 1'b0, 32'd2);
    do_write(1'b1, 1'b0, 32'd4);
    do_read(1'b0, 1'b0, r, rc);
    check("R6 group-0 untouched by dropped write", r, 32'd2);
    common_mode = 1'b0;
    do_read(1'b1, 1'b0, r, rc);
    check("R6 stored group-1 untouched", r, 32'(m1));
    check("R6 stored group-1 still 6", r, 32'd6);
  endtask

  task automatic t_common_secure();
    logic [31:0] r, rc;
    common_mode = 1'b1;
    do_write(1'b0, 1'b0, 32'd4);
    do_read(1'b1, 1'b1, r, rc);
    check("R7 secure read returns group-0", r, 32'd4);
    do_write(1'b1, 1'b1, 32'd2);
    do_read(1'b0, 1'b0, r, rc);
    check("R7 secure write lands in group-0", r, 32'd2);
    do_write(1'b1, 1'b1, 32'd0);
    do_read(1'b0, 1'b0, r, rc);
    check("R7 redirected write uses group-0 floor", rc, 32'd2);
    check("R7 redirected write of 0 at default floor", r, 32'd0);
    common_mode = 1'b0;
    do_read(1'b1, 1'b0, r, rc);
    check("R7 stored group-1 untouched", r, 32'd6);
    check("R7 raised instance group-1 untouched", rc, 32'(c1));
  endtask

  task automatic t_masks();
    common_mode = 1'b0;
    do_write(1'b1, 1'b0, 32'd3);
    do_write(1'b0, 1'b0, 32'd3);
    check("R8 mask1 bp=3", 32'(mask1), 32'hF8);
    check("R8 mask0 bp=3", 32'(mask0), 32'hF0);
    do_write(1'b0, 1'b0, 32'd7);
    check("R8 mask0 bp=7", 32'(mask0), 32'h00);
  endtask

  initial begin
    #100_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_grp0_rw();
    t_grp1_floor();
    t_idle();
    t_common_ns_read();
    t_common_ns_write();
    t_common_secure();
    t_masks();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule